// File: doc/BRIEF.md
# Serial Flash Slave Front End with Hold

This block is the bit-level front end of a serial-flash slave on a four-wire SPI bus. It runs in one fast system clock domain. It samples the serial clock, chip select, hold and data-in pins through a short synchronizer and detects clock edges from the synchronized levels. Both clock polarities work: idle-low (mode 0) and idle-high (mode 3).

Incoming bits are taken on rising serial-clock edges, most significant bit first, and packed into bytes. After each complete byte the block raises a one-cycle strobe that carries the byte and its position within the current select frame. The command logic above it decodes these bytes.

To answer, the command logic hands over a response byte through a load strobe at any time before a byte boundary. The block shifts that byte out on falling serial-clock edges, most significant bit first, and enables the output only while it is doing so.

An active-low hold input pauses the transfer without losing its place. Hold is entered and left only while the serial clock is low. During hold the output floats and the serial clock and data-in pins are ignored. Deselecting the part clears the transfer state, whether or not hold is active.

Top module: `spiHoldFrontEnd`

## Requirements
- R1: On the rising serial-clock edges, data-in is captured most significant bit first. After the eighth bit, `byteValid` is high for exactly one system clock, and `byteData` then carries the assembled byte.
- R2: `byteIndex` gives the position of the strobed byte within the current select frame. The first byte after chip select falls is index 0, and each further byte adds 1.
- R3: `bitCount` shows how many bits of the current byte have been captured (0 to 7). It returns to 0 at each byte boundary.
- R4: A byte given through `rspLoad`/`rspData` before a byte boundary is driven on `misoOut` starting at the falling edge that follows that boundary. Bit 7 comes first and one bit follows per falling edge. `misoOe` is high while that byte is on the line.
- R5: `misoOe` is low whenever chip select is high, and during any byte for which no response was loaded, such as command and address bytes.
- R6: Capture and shifting work the same whether the serial clock idles low (mode 0) or high (mode 3) while chip select falls.
- R7: If chip select rises before the eighth bit of a byte, no strobe is issued for that byte. The next frame starts again at bit 0 and byte index 0.
- R8: Hold starts or ends only while the serial clock is low. A hold pin change made while the clock is high takes effect at the next low phase.
- R9: While hold is in effect, `misoOe` is low, and serial-clock edges and data-in changes do not change `bitCount`, captured data or output data.
- R10: Chip select rising while hold is in effect clears the transfer state. `bitCount` goes to 0, the output is disabled, and the next frame starts at byte index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckPin | input | 1 | Serial clock pin (asynchronous) |
| csNPin | input | 1 | Chip select pin, active low (asynchronous) |
| holdNPin | input | 1 | Hold pin, active low (asynchronous) |
| mosiPin | input | 1 | Serial data in pin (asynchronous) |
| rspData | input | DATA_W (8) | Response byte from the command logic |
| rspLoad | input | 1 | One-cycle strobe that latches `rspData` for the next byte boundary |
| byteValid | output | 1 | One-cycle strobe: a received byte is complete |
| byteData | output | DATA_W (8) | Received byte, valid with `byteValid` |
| byteIndex | output | IDX_W (8) | Position of the strobed byte in the frame |
| bitCount | output | $clog2(DATA_W) (3) | Bits captured so far in the current byte |
| misoOut | output | 1 | Serial data out value |
| misoOe | output | 1 | Output enable for the serial data out pin |

## Verification
Some properties are checked by assertions on every cycle:
- the byte strobe never lasts two cycles;
- the hold state changes only in a cycle that follows a low serial-clock sample;
- the bit counter stays frozen while hold persists;
- deselection clears the counter and the output enable;
- the output enable starts only at a byte-boundary falling edge.

Other behaviour only the bench scenarios can show:
- that the captured bytes and the shifted-out response bits carry the right values in both clock polarities;
- that a hold change made during a high phase is deferred as seen at the output enable;
- that aborted and hold-reset frames restart at index 0.

// File: rtl/spiHoldPkg.sv
package spiHoldPkg;

  // Control-to-datapath strobes, all in the system clock domain
  typedef struct packed {
    logic selected;  // chip select active (synchronized level)
    logic holdOn;    // hold in effect
    logic frameClr;  // clear all per-frame state
    logic capture;   // qualified rising serial-clock edge
    logic launch;    // qualified falling serial-clock edge
  } spiStrobe_t;

endpackage

// File: rtl/spiPinSync.sv
module spiPinSync #(
  parameter int STAGES = 2,
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);

  logic [W-1:0] stageQ [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= RST_VAL;
        else       stageQ[g] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= RST_VAL;
        else       stageQ[g] <= stageQ[g-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/spiHoldCtl.sv
module spiHoldCtl
  import spiHoldPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckLvl,
  input  logic       csNLvl,
  input  logic       holdNLvl,
  output spiStrobe_t strobe
);

  logic sckPrev;
  logic inHold;
  logic selected;
  logic sckRise;
  logic sckFall;

  assign selected = ~csNLvl;
  assign sckRise  = sckLvl & ~sckPrev;
  assign sckFall  = ~sckLvl & sckPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sckLvl;
  end

  // hold follows the pin only during a low serial-clock phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          inHold <= 1'b0;
    else if (!selected) inHold <= 1'b0;
    else if (!sckLvl)   inHold <= ~holdNLvl;
  end

  always_comb begin
    strobe.selected = selected;
    strobe.holdOn   = inHold;
    strobe.frameClr = ~selected;
    strobe.capture  = selected & ~inHold & sckRise;
    strobe.launch   = selected & ~inHold & sckFall;
  end

  // R8
  hold_low_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selected && $past(selected) && (inHold != $past(inHold))) |-> !$past(sckLvl));

endmodule

// File: rtl/spiHoldDp.sv
module spiHoldDp
  import spiHoldPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  spiStrobe_t                strobe,
  input  logic                      mosiLvl,
  input  logic [DATA_W-1:0]         rspData,
  input  logic                      rspLoad,
  output logic                      byteValid,
  output logic [DATA_W-1:0]         byteData,
  output logic [IDX_W-1:0]          byteIndex,
  output logic [$clog2(DATA_W)-1:0] bitCount,
  output logic                      misoOut,
  output logic                      misoOe
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

  logic [DATA_W-2:0] shiftIn;
  logic [CNT_W-1:0]  bitCnt;
  logic [IDX_W-1:0]  byteIdx;
  logic [DATA_W-1:0] pendByte;
  logic              pendValid;
  logic [DATA_W-1:0] txShift;
  logic              txOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftIn   <= '0;
      bitCnt    <= '0;
      byteIdx   <= '0;
      pendByte  <= '0;
      pendValid <= 1'b0;
      txShift   <= '0;
      txOn      <= 1'b0;
      byteValid <= 1'b0;
      byteData  <= '0;
      byteIndex <= '0;
    end else begin
      byteValid <= 1'b0;
      if (strobe.frameClr) begin
        bitCnt    <= '0;
        byteIdx   <= '0;
        pendValid <= 1'b0;
        txOn      <= 1'b0;
      end else begin
        if (rspLoad) begin
          pendByte  <= rspData;
          pendValid <= 1'b1;
        end
        if (strobe.capture) begin
          shiftIn <= {shiftIn[DATA_W-3:0], mosiLvl};
          if (bitCnt == LAST_BIT) begin
            bitCnt    <= '0;
            byteValid <= 1'b1;
            byteData  <= {shiftIn, mosiLvl};
            byteIndex <= byteIdx;
            byteIdx   <= byteIdx + IDX_ONE;
          end else begin
            bitCnt <= bitCnt + CNT_ONE;
          end
        end
        if (strobe.launch) begin
          if (bitCnt == '0) begin
            txOn    <= pendValid;
            txShift <= pendByte;
            if (pendValid) pendValid <= 1'b0;
          end else begin
            txShift <= {txShift[DATA_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign bitCount = bitCnt;
  assign misoOut  = txShift[DATA_W-1];
  assign misoOe   = strobe.selected & ~strobe.holdOn & txOn;

  // R1
  byte_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.holdOn) && $past(strobe.selected) && strobe.selected)
      |-> (bitCnt == $past(bitCnt)));

  // R7
  deselect_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.selected |=> (bitCnt == '0 && !txOn));

  // R4
  tx_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txOn) |-> ($past(strobe.launch) && $past(bitCnt) == '0));

endmodule

// File: rtl/spiHoldFrontEnd.sv
module spiHoldFrontEnd
  import spiHoldPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sckPin,
  input  logic                      csNPin,
  input  logic                      holdNPin,
  input  logic                      mosiPin,
  input  logic [DATA_W-1:0]         rspData,
  input  logic                      rspLoad,
  output logic                      byteValid,
  output logic [DATA_W-1:0]         byteData,
  output logic [IDX_W-1:0]          byteIndex,
  output logic [$clog2(DATA_W)-1:0] bitCount,
  output logic                      misoOut,
  output logic                      misoOe
);

  logic [3:0] pinSync;
  spiStrobe_t strobe;

  // bit order: {sck, csN, holdN, mosi}; select and hold reset inactive
  spiPinSync #(.STAGES(SYNC_STAGES), .W(4), .RST_VAL(4'b0110)) i_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({sckPin, csNPin, holdNPin, mosiPin}),
    .syncOut(pinSync)
  );

  spiHoldCtl i_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .sckLvl  (pinSync[3]),
    .csNLvl  (pinSync[2]),
    .holdNLvl(pinSync[1]),
    .strobe  (strobe)
  );

  spiHoldDp #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .mosiLvl  (pinSync[0]),
    .rspData  (rspData),
    .rspLoad  (rspLoad),
    .byteValid(byteValid),
    .byteData (byteData),
    .byteIndex(byteIndex),
    .bitCount (bitCount),
    .misoOut  (misoOut),
    .misoOe   (misoOe)
  );

endmodule

// File: tb/test_spiHoldFrontEnd.sv
`timescale 1ns/1ps
module test_spiHoldFrontEnd;

  localparam int H = 8;  // system clocks per serial-clock half period

  typedef struct packed {
    logic       mode3;
    logic       useRsp;
    logic [7:0] cmd;
    logic [7:0] nxt;
    logic [7:0] rsp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 1'b1, 8'hA3, 8'h00, 8'h5C},
    '{1'b1, 1'b1, 8'h0F, 8'hF0, 8'h81},
    '{1'b0, 1'b0, 8'hFF, 8'h55, 8'h00},
    '{1'b1, 1'b0, 8'h01, 8'h80, 8'h00},
    '{1'b0, 1'b1, 8'h6E, 8'hC3, 8'hFF},
    '{1'b1, 1'b1, 8'h00, 8'h7A, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sck = 1'b0, csN = 1'b1, holdN = 1'b1, mosi = 1'b0;
  logic [7:0] rspData = 8'h00;
  logic       rspLoad = 1'b0;
  logic       byteValid, misoOut, misoOe;
  logic [7:0] byteData, byteIndex;
  logic [2:0] bitCount;

  int checks = 0, fails = 0, strobeCnt = 0;
  logic [7:0] lastData = 8'h00, lastIdx = 8'h00;

  always #2.5 clk = ~clk;

  spiHoldFrontEnd i_spiHoldFrontEnd (
    .clk(clk), .rstN(rstN), .sckPin(sck), .csNPin(csN), .holdNPin(holdN),
    .mosiPin(mosi), .rspData(rspData), .rspLoad(rspLoad),
    .byteValid(byteValid), .byteData(byteData), .byteIndex(byteIndex),
    .bitCount(bitCount), .misoOut(misoOut), .misoOe(misoOe)
  );

  always @(negedge clk) begin
    if (rstN && byteValid) begin
      strobeCnt = strobeCnt + 1;
      lastData  = byteData;
      lastIdx   = byteIndex;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doBit(input logic b, output logic so, output logic oe);
    sck = 1'b0; mosi = b;
    waitN(H);
    so = misoOut; oe = misoOe;
    sck = 1'b1;
    waitN(H);
  endtask

  task automatic sendByte(input logic [7:0] tx, output logic [7:0] rx, output int oeCnt,
                          input logic loadRsp, input logic [7:0] rsp);
    logic so, oe;
    oeCnt = 0;
    for (int i = 7; i >= 0; i--) begin
      doBit(tx[i], so, oe);
      rx[i] = so;
      oeCnt += int'(oe);
      if (loadRsp && i == 3) begin
        rspData = rsp; rspLoad = 1'b1;
        waitN(1);
        rspLoad = 1'b0;
      end
    end
  endtask

  task automatic frameStart(input logic mode3);
    sck = mode3;
    waitN(4);
    csN = 1'b0;
    waitN(4);
  endtask

  task automatic frameEnd(input logic mode3);
    if (!mode3) begin
      sck = 1'b0;
      waitN(H);
    end
    csN = 1'b1;
    waitN(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    logic so, oe;
    int oec, base;
    vec_t v;

    waitN(4);
    rstN = 1'b1;
    waitN(4);
    // reset state
    chk("R1 reset byteValid", byteValid, 0);
    chk("R5 reset misoOe", misoOe, 0);
    chk("R3 reset bitCount", bitCount, 0);
    chk("R2 reset byteIndex", byteIndex, 0);

    // vector table: two-byte frames in both clock polarities
    for (int k = 0; k < 6; k++) begin
      v = VEC[k];
      base = strobeCnt;
      frameStart(v.mode3);
      sendByte(v.cmd, rx, oec, v.useRsp, v.rsp);
      chk(v.mode3 ? "R1 R6 byte0 data" : "R1 byte0 data", lastData, v.cmd);
      chk("R2 byte0 index", lastIdx, 0);
      chk("R5 oe during command byte", oec, 0);
      sendByte(v.nxt, rx, oec, 1'b0, 8'h00);
      chk(v.mode3 ? "R1 R6 byte1 data" : "R1 byte1 data", lastData, v.nxt);
      chk("R2 byte1 index", lastIdx, 1);
      if (v.useRsp) begin
        chk(v.mode3 ? "R4 R6 response bits" : "R4 response bits", rx, v.rsp);
        chk("R4 oe during response", oec, 8);
      end else begin
        chk("R5 oe without response", oec, 0);
      end
      frameEnd(v.mode3);
      chk("R5 oe after deselect", misoOe, 0);
      chk("R1 strobe count", strobeCnt - base, 2);
      chk("R3 bitCount at rest", bitCount, 0);
    end

    // hold changed while clock high: deferred entry and exit, mode 0
    base = strobeCnt;
    frameStart(1'b0);
    sendByte(8'h3C, rx, oec, 1'b1, 8'hA5);
    for (int i = 7; i >= 5; i--) begin
      doBit(rx[0] ^ 1'b0 ^ 1'b0 | 1'b0 ? 1'b0 : (8'h96 >> i) & 8'h01 ? 1'b1 : 1'b0, so, oe);
      rx[i] = so;
    end
    holdN = 1'b0;
    waitN(4);
    chk("R8 hold entry deferred while clock high", misoOe, 1);
    sck = 1'b0; mosi = 1'b0;
    waitN(H);
    chk("R9 output floats in hold", misoOe, 0);
    chk("R3 bitCount before junk clocks", bitCount, 3);
    for (int j = 0; j < 2; j++) begin
      sck = 1'b1; mosi = ~mosi;
      waitN(H);
      sck = 1'b0;
      waitN(H);
    end
    chk("R9 clock edges ignored in hold", bitCount, 3);
    sck = 1'b1;
    waitN(4);
    holdN = 1'b1;
    waitN(4);
    chk("R8 hold exit deferred while clock high", misoOe, 0);
    for (int i = 4; i >= 0; i--) begin
      doBit(((8'h96 >> i) & 8'h01) != 0, so, oe);
      rx[i] = so;
    end
    chk("R9 response intact across hold", rx, 8'hA5);
    chk("R9 received byte intact across hold", lastData, 8'h96);
    chk("R9 no extra strobe from held clocks", strobeCnt - base, 2);
    frameEnd(1'b0);

    // hold changed while clock low: immediate, mode 3
    frameStart(1'b1);
    for (int i = 7; i >= 4; i--) doBit(((8'hC9 >> i) & 8'h01) != 0, so, oe);
    chk("R3 bitCount mid byte", bitCount, 4);
    sck = 1'b0; mosi = 1'b1;
    waitN(H);
    holdN = 1'b0;
    waitN(5);
    sck = 1'b1;
    waitN(H);
    chk("R8 hold entered at once while clock low", bitCount, 4);
    sck = 1'b0;
    waitN(2);
    holdN = 1'b1;
    waitN(5);
    sck = 1'b1;
    waitN(H);
    chk("R8 hold left at once while clock low", bitCount, 5);
    for (int i = 2; i >= 0; i--) doBit(((8'hC9 >> i) & 8'h01) != 0, so, oe);
    chk("R8 byte after hold", lastData, 8'hC9);
    chk("R2 byte after hold index", lastIdx, 0);
    frameEnd(1'b1);

    // deselect during hold resets the interface
    base = strobeCnt;
    frameStart(1'b0);
    for (int i = 0; i < 3; i++) doBit(1'b1, so, oe);
    sck = 1'b0;
    holdN = 1'b0;
    waitN(6);
    csN = 1'b1;
    waitN(6);
    holdN = 1'b1;
    waitN(4);
    chk("R10 bitCount cleared by deselect in hold", bitCount, 0);
    chk("R10 oe low after deselect in hold", misoOe, 0);
    frameStart(1'b0);
    sendByte(8'h4B, rx, oec, 1'b0, 8'h00);
    chk("R10 next frame data", lastData, 8'h4B);
    chk("R10 next frame index", lastIdx, 0);
    chk("R10 single strobe", strobeCnt - base, 1);
    frameEnd(1'b0);

    // abort mid byte without hold
    base = strobeCnt;
    frameStart(1'b1);
    for (int i = 0; i < 5; i++) doBit(1'b0, so, oe);
    csN = 1'b1;
    waitN(6);
    chk("R7 no strobe on partial byte", strobeCnt - base, 0);
    chk("R7 bitCount cleared by abort", bitCount, 0);
    frameStart(1'b1);
    sendByte(8'hD2, rx, oec, 1'b0, 8'h00);
    chk("R7 fresh byte after abort", lastData, 8'hD2);
    chk("R7 index restarts after abort", lastIdx, 0);
    frameEnd(1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule